// File: doc/BRIEF.md
# Interrupt coalescing and credit controller

This block is a single interrupt resource. It watches a one-cycle event input and decides when to issue a one-cycle interrupt pulse. Three things hold an interrupt back: a mask bit, an optional automatic re-mask each time an interrupt goes out, and a coalescing countdown. The countdown is reloaded on every send and steps down once per strobe of an external prescaler. An event that arrives while the resource is held back is remembered and goes out as soon as the hold is lifted.

Every interrupt sent adds one to a signed credit counter. Software pays credits back by writing a count to the credit register, and the hardware subtracts it in one step. When the counter lands on zero, the pending status and any event still waiting to be sent are dropped. The same credit write carries two flag bits. One clears the mask and the other restarts the countdown, so setting both re-arms the resource in a single access.

Software reaches the controls through a 32-byte window with a plain write port and a combinational read port.

Top module: `intr_coal_ctrl`

## Requirements
- R1: After reset the mask reads 1. The coalescing init value, auto-mask bit, credit count and current countdown all read 0. `pending_o` and `irq_o` are 0.
- R2: While the mask is 1, no interrupt is issued, and an event that arrives is kept. Writing 0 to bit 0 at offset 0x04 lets the kept event go out. An event seen at a clock edge sends `irq_o` high for the whole following cycle, provided the countdown is 0 and the mask is 0.
- R3: With a coalescing init value of 0, every event yields exactly one interrupt in the cycle after it. This includes events on consecutive cycles.
- R4: Each send loads the current countdown (readable at offset 0x10) from the init value at offset 0x00. The countdown then drops by 1 on each cycle with `tick_i` high and holds at 0. No interrupt is sent while it is nonzero. An event kept while it counts goes out in the first cycle it reads 0.
- R5: A write to offset 0x00 stores the value, saturated to 63 when it exceeds 63.
- R6: The credit count, read in bits 15:0 at offset 0x08, rises by 1 for each interrupt sent and wraps as a 16-bit two's-complement value.
- R7: A write to offset 0x08 subtracts bits 14:0 of the write data from the credit count, in the same cycle as any concurrent send. When the result is 0, `pending_o` and any unsent event are cleared. An event arriving in that same cycle is still kept. `pending_o` is set by every send.
- R8: In a write to offset 0x08, bit 16 sets the mask to 0 and bit 17 reloads the countdown from the init value. A direct mask write at 0x04 overrides the automatic mask, and bit 16 also overrides it.
- R9: With bit 0 at offset 0x0C set to 1, every send sets the mask to 1.
- R10: Offset 0x10 is read-only. Offsets 0x14 to 0x1C, and any address whose low two bits are not 0, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational |
| event_i | input | 1 | Interrupt assertion event |
| tick_i | input | 1 | Prescaler strobe for the countdown |
| irq_o | output | 1 | One-cycle interrupt send pulse |
| pending_o | output | 1 | Interrupt status: sent and not yet paid back |

## Verification
The bench builds the block with its default widths: a 6-bit countdown, a 16-bit credit counter and a 32-bit data path. The 6-bit countdown keeps the saturation value of 63 and a full countdown within a few hundred cycles, so clamped loads, coalesced bursts and reloads in mid-count can all be reached. The 16-bit credit field lets an over-subtraction go negative and come back to zero within a short sequence. This exercises both the sign wrap and the clear-on-zero rule.

// File: rtl/intr_coal_pkg.sv
package intr_coal_pkg;
  // word indices inside the 32-byte window
  localparam int unsigned IDX_COAL = 0;
  localparam int unsigned IDX_MASK = 1;
  localparam int unsigned IDX_CRED = 2;
  localparam int unsigned IDX_MOA  = 3;
  localparam int unsigned IDX_CUR  = 4;

  typedef struct packed {
    logic coal;
    logic mask;
    logic cred;
    logic moa;
  } wr_sel_t;
endpackage

// File: rtl/intr_coal_regs.sv
module intr_coal_regs
  import intr_coal_pkg::*;
#(
  parameter int unsigned COAL_W = 6,
  parameter int unsigned CRED_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_sel_t           wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              unmask_i,
  input  logic              fire_i,
  input  logic              rd_ok_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [CRED_W-1:0] credits_i,
  input  logic [COAL_W-1:0] cur_i,
  output logic [COAL_W-1:0] coal_init_o,
  output logic              mask_o,
  output logic              moa_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [COAL_W-1:0] COAL_MAX = '1;

  logic [COAL_W-1:0] coal_wval;

  generate
    if (DATA_W > COAL_W) begin : g_clamp
      assign coal_wval = (|wr_data_i[DATA_W-1:COAL_W]) ? COAL_MAX
                                                        : wr_data_i[COAL_W-1:0];
    end else begin : g_direct
      assign coal_wval = wr_data_i[COAL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coal_init_o <= '0;
      moa_o       <= 1'b0;
    end else begin
      if (wr_sel_i.coal) coal_init_o <= coal_wval;
      if (wr_sel_i.moa)  moa_o       <= wr_data_i[0];
    end
  end

  // software writes win over the automatic mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_o <= 1'b1;
    else if (wr_sel_i.mask)     mask_o <= wr_data_i[0];
    else if (unmask_i)          mask_o <= 1'b0;
    else if (fire_i && moa_o)   mask_o <= 1'b1;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_ok_i) begin
      case (int'(rd_idx_i))
        IDX_COAL: rd_data_o[COAL_W-1:0] = coal_init_o;
        IDX_MASK: rd_data_o[0]          = mask_o;
        IDX_CRED: rd_data_o[CRED_W-1:0] = credits_i;
        IDX_MOA:  rd_data_o[0]          = moa_o;
        IDX_CUR:  rd_data_o[COAL_W-1:0] = cur_i;
        default:  rd_data_o             = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_coal_timer.sv
module intr_coal_timer #(
  parameter int unsigned COAL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              fire_i,
  input  logic              tick_i,
  input  logic [COAL_W-1:0] coal_init_i,
  output logic [COAL_W-1:0] cur_o,
  output logic              zero_o
);
  assign zero_o = (cur_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cur_o <= '0;
    else if (reload_i || fire_i) cur_o <= coal_init_i;
    else if (tick_i && !zero_o)  cur_o <= cur_o - 1'b1;
  end
endmodule

// File: rtl/intr_coal_credit.sv
module intr_coal_credit #(
  parameter int unsigned CRED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              event_i,
  input  logic              cred_wr_i,
  input  logic [CRED_W-2:0] dec_i,
  output logic [CRED_W-1:0] credits_o,
  output logic              status_o,
  output logic              unsent_o
);
  logic [CRED_W-1:0] inc, sub, nxt;
  logic              clr;

  assign inc = {{(CRED_W-1){1'b0}}, fire_i};
  assign sub = cred_wr_i ? {1'b0, dec_i} : '0;
  assign nxt = credits_o + inc - sub;
  assign clr = cred_wr_i && (nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credits_o <= '0;
      status_o  <= 1'b0;
      unsent_o  <= 1'b0;
    end else begin
      credits_o <= nxt;
      status_o  <= clr ? 1'b0 : (status_o | fire_i);
      if (clr || fire_i) unsent_o <= event_i;
      else               unsent_o <= unsent_o | event_i;
    end
  end
endmodule

// File: rtl/intr_coal_ctrl.sv
module intr_coal_ctrl
  import intr_coal_pkg::*;
#(
  parameter int unsigned COAL_W = 6,
  parameter int unsigned CRED_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              event_i,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              pending_o
);
  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned UNMASK_BIT = CRED_W;
  localparam int unsigned RELOAD_BIT = CRED_W + 1;

  wr_sel_t           wr_sel;
  logic              wr_ok, rd_ok;
  logic [IDX_W-1:0]  wr_idx;
  logic              cred_wr, unmask, reload, fire;
  logic [COAL_W-1:0] coal_q, cur_q;
  logic              mask_q, moa_q, cur_zero, unsent_q;
  logic [CRED_W-1:0] cred_q;

  assign wr_ok  = wr_en_i && (wr_addr_i[1:0] == 2'b00);
  assign rd_ok  = (rd_addr_i[1:0] == 2'b00);
  assign wr_idx = wr_addr_i[ADDR_W-1:2];

  always_comb begin
    wr_sel      = '0;
    wr_sel.coal = wr_ok && (int'(wr_idx) == IDX_COAL);
    wr_sel.mask = wr_ok && (int'(wr_idx) == IDX_MASK);
    wr_sel.cred = wr_ok && (int'(wr_idx) == IDX_CRED);
    wr_sel.moa  = wr_ok && (int'(wr_idx) == IDX_MOA);
  end

  assign cred_wr = wr_sel.cred;
  assign unmask  = cred_wr && wr_data_i[UNMASK_BIT];
  assign reload  = cred_wr && wr_data_i[RELOAD_BIT];
  assign fire    = unsent_q && !mask_q && cur_zero;

  intr_coal_regs #(
    .COAL_W(COAL_W), .CRED_W(CRED_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data_i),
    .unmask_i   (unmask),
    .fire_i     (fire),
    .rd_ok_i    (rd_ok),
    .rd_idx_i   (rd_addr_i[ADDR_W-1:2]),
    .credits_i  (cred_q),
    .cur_i      (cur_q),
    .coal_init_o(coal_q),
    .mask_o     (mask_q),
    .moa_o      (moa_q),
    .rd_data_o  (rd_data_o)
  );

  intr_coal_timer #(.COAL_W(COAL_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload),
    .fire_i     (fire),
    .tick_i     (tick_i),
    .coal_init_i(coal_q),
    .cur_o      (cur_q),
    .zero_o     (cur_zero)
  );

  intr_coal_credit #(.CRED_W(CRED_W)) u_credit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .event_i  (event_i),
    .cred_wr_i(cred_wr),
    .dec_i    (wr_data_i[CRED_W-2:0]),
    .credits_o(cred_q),
    .status_o (pending_o),
    .unsent_o (unsent_q)
  );

  assign irq_o = fire;
endmodule

// File: rtl/intr_coal_ctrl_chk.sv
module intr_coal_ctrl_chk #(
  parameter int unsigned COAL_W = 6,
  parameter int unsigned CRED_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              pending_i,
  input logic              mask_i,
  input logic              moa_i,
  input logic              mask_wr_i,
  input logic              cred_wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [COAL_W-1:0] cur_i,
  input logic [COAL_W-1:0] coal_i,
  input logic [CRED_W-1:0] cred_i
);
  p_mask_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !irq_i);

  p_timer_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i != '0) |-> !irq_i);

  p_reload_on_send_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (cur_i == $past(coal_i)));

  p_credit_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !cred_wr_i) |=> (cred_i == $past(cred_i) + CRED_W'(1)));

  p_zero_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cred_wr_i && !irq_i && ({1'b0, wr_data_i[CRED_W-2:0]} == cred_i))
      |=> !pending_i);

  p_automask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && moa_i && !mask_wr_i && !(cred_wr_i && wr_data_i[CRED_W]))
      |=> mask_i);
endmodule

bind intr_coal_ctrl intr_coal_ctrl_chk #(
  .COAL_W(COAL_W), .CRED_W(CRED_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .pending_i(pending_o),
  .mask_i   (mask_q),
  .moa_i    (moa_q),
  .mask_wr_i(wr_sel.mask),
  .cred_wr_i(cred_wr),
  .wr_data_i(wr_data_i),
  .cur_i    (cur_q),
  .coal_i   (coal_q),
  .cred_i   (cred_q)
);

// File: tb/intr_coal_ctrl_tb.sv
`timescale 1ns/100ps
module intr_coal_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ev = 1'b0;
  logic        tick = 1'b0;
  logic        irq, pend;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    tick_en = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  intr_coal_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .event_i(ev), .tick_i(tick), .irq_o(irq), .pending_o(pend)
  );

  // behavioural reference state
  int          m_coal = 0, m_cur = 0;
  bit          m_mask = 1, m_moa = 0, m_stat = 0, m_uns = 0;
  logic [15:0] m_cred = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_coal = 0; m_cur = 0; m_mask = 1; m_moa = 0;
      m_stat = 0; m_uns = 0; m_cred = '0;
    end else begin
      bit f, cw, clr, mw;
      logic [15:0] nc;
      f  = m_uns && !m_mask && (m_cur == 0);
      cw = wr_en && (wr_addr == 5'h08);
      mw = wr_en && (wr_addr == 5'h04);
      nc = m_cred + (f ? 16'd1 : 16'd0) - (cw ? {1'b0, wr_data[14:0]} : 16'd0);
      clr = cw && (nc == 16'd0);
      m_cred = nc;
      m_stat = clr ? 0 : (m_stat | f);
      m_uns  = (clr || f) ? ev : (m_uns | ev);
      if (cw && wr_data[17])        m_cur = m_coal;
      else if (f)                   m_cur = m_coal;
      else if (tick && m_cur > 0)   m_cur = m_cur - 1;
      if (mw)                       m_mask = wr_data[0];
      else if (cw && wr_data[16])   m_mask = 0;
      else if (f && m_moa)          m_mask = 1;
      if (wr_en && wr_addr == 5'h00) m_coal = (wr_data > 63) ? 63 : int'(wr_data);
      if (wr_en && wr_addr == 5'h0C) m_moa = wr_data[0];
    end
  end

  // input drivers for reads and ticks, clear of the edge
  always @(posedge clk) begin
    #1;
    rd_addr <= (rd_addr >= 5'h1C) ? 5'h00 : rd_addr + 5'h04;
    tick    <= tick_en && !tick;
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] er;
      case (rd_addr)
        5'h00:   er = 32'(m_coal);
        5'h04:   er = {31'd0, m_mask};
        5'h08:   er = {16'd0, m_cred};
        5'h0C:   er = {31'd0, m_moa};
        5'h10:   er = 32'(m_cur);
        default: er = '0;
      endcase
      chk("irq", {31'd0, irq}, {31'd0, (m_uns && !m_mask && m_cur == 0)});
      chk("pending", {31'd0, pend}, {31'd0, m_stat});
      chk("rd_data", rd_data, er);
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic pulse(int n);
    @(posedge clk); #1;
    ev = 1'b1;
    repeat (n) @(posedge clk);
    #1 ev = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R1"; idle(3); #1 rst_n = 1'b1; idle(8);
    tag = "R2"; pulse(1); idle(6); wr(5'h04, 32'h0); idle(4);
    tag = "R7"; wr(5'h08, 32'h1); idle(4);
    tag = "R3"; pulse(1); idle(3); pulse(3); idle(3);
    pulse(1); idle(1); pulse(1); idle(3);
    tag = "R6"; wr(5'h08, 32'h2); idle(3); wr(5'h08, 32'h3); idle(6);
    tag = "R5"; wr(5'h00, 32'h0000_1000); idle(6); wr(5'h00, 32'h40); idle(6);
    wr(5'h00, 32'h3F); idle(6); wr(5'h00, 32'h5); idle(6);
    tag = "R4"; tick_en = 1; pulse(1); idle(2); pulse(1); idle(2); pulse(2);
    idle(20); pulse(1); idle(30);
    tag = "R8"; pulse(1); idle(3); wr(5'h08, 32'h0002_0000); idle(4);
    pulse(1); idle(30);
    tag = "R9"; wr(5'h0C, 32'h1); pulse(1); idle(4); pulse(1); idle(20);
    wr(5'h08, 32'h0003_0000); idle(30); wr(5'h08, 32'h0001_0000); idle(30);
    tag = "R7"; wr(5'h08, 32'h0000_7FFF); idle(6); wr(5'h08, 32'h0000_0000); idle(4);
    wr(5'h0C, 32'h0); wr(5'h04, 32'h0); wr(5'h00, 32'h0);
    pulse(2); idle(3); wr(5'h08, 32'h2); idle(4);
    tag = "R10"; wr(5'h10, 32'h3); idle(6); wr(5'h14, 32'hFFFF_FFFF); idle(6);
    wr(5'h1C, 32'h1); idle(6); wr(5'h01, 32'h3); wr(5'h05, 32'h1); idle(8);
    tag = "R2"; wr(5'h04, 32'h1); pulse(1); idle(5); wr(5'h08, 32'h0001_0000); idle(6);
    tick_en = 0; idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule